// File: doc/BRIEF.md
# Left-to-Right Modular Exponentiation Engine

This block raises a base to an exponent modulo a modulus. The base, exponent and modulus are each 16 bits wide, which suits small public-key encryption and decryption. The caller presents all three operands together with a one-cycle `start` pulse while the engine is idle. The engine captures the operands and scans the exponent from its highest set bit down to bit 0. For every bit it first multiplies the running value by the base if the bit is one, then squares the running value unless the bit is the last. Leading zero bits of the exponent cost nothing, so a short public exponent finishes far sooner than a long private one.

All products are formed by a shift-add modular multiplier inside the block. That multiplier keeps both of its partial values below the modulus at every step, and it stops as soon as the remaining multiplier bits are zero. Before the exponent scan starts, one multiplication of the base by one brings a base that is at or above the modulus into range. An exponent of zero skips all multiplication work.

The interface is plain control rather than a stream, because one operand set produces one result. `start` is a request that is taken only while `busy` is low. There is no back-pressure: `done` is a single-cycle pulse, and `result` holds its value until the next accepted request completes.

Top module: `modexp_lr`

## Requirements
- R1: When `done` pulses, `result` equals base^exponent mod modulus for any modulus of at least 1, including a base at or above the modulus.
- R2: A request with exponent 0 raises `done` in the first cycle after the accepting edge, with `result` = 1 mod modulus, and starts no multiplication.
- R3: `done` is high for exactly one cycle per accepted request, and `busy` stays high from the accepting edge through the `done` cycle.
- R4: A `start` pulse while `busy` is high is ignored: the result delivered is that of the request already in progress, and no extra `done` is produced.
- R5: Whenever `done` is high, `result` is below the modulus captured with the request.
- R6: A modulus of 1 yields a result of 0 for every base and exponent.
- R7: Encrypting a message with a public exponent and then decrypting the result with the matching private exponent, both under the same modulus, restores the message.
- R8: After reset, `busy` and `done` are low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when `busy` is low |
| base | input | 16 | Base operand, any value |
| exponent | input | 16 | Exponent operand |
| modulus | input | 16 | Modulus, must be nonzero |
| busy | output | 1 | High from the accepting edge until after the `done` cycle |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 16 | base^exponent mod modulus, held until the next completion |

## Verification
The assertions assume that a request never carries a modulus of zero. The bound checks on the multiplier's running values and on `result` depend on that. The stimulus therefore draws the modulus from 1 upward and never from the full 16-bit range. Random bases cover the whole 16-bit range, so many of them exceed the modulus. Directed cases add a zero exponent, an all-ones exponent, a modulus of 1, and a start pulse injected during a busy run.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RED  = 3'd1,
    ST_MUL  = 3'd2,
    ST_SQR  = 3'd3,
    ST_DONE = 3'd4
  } mx_state_e;
endpackage

// File: rtl/modexp_lead_one.sv
module modexp_lead_one #(
  parameter int W  = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] pos
);
  // position of the highest set bit; 0 when vec is zero
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = IW'(i);
    end
  end
endmodule

// File: rtl/modexp_mulmod.sv
module modexp_mulmod #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_n,
  output logic         fin,
  output logic [W-1:0] prod
);
  logic         run;
  logic [W-1:0] acc_m, dbl_p, scan_b, mod_q;

  // (x + y) mod n for x, y < n
  function automatic logic [W-1:0] add_mod(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic [W-1:0] n);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      fin    <= 1'b0;
      acc_m  <= '0;
      dbl_p  <= '0;
      scan_b <= '0;
      mod_q  <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        run    <= 1'b1;
        acc_m  <= '0;
        dbl_p  <= op_a;
        scan_b <= op_b;
        mod_q  <= op_n;
      end else if (run) begin
        if (scan_b == '0) begin
          run <= 1'b0;
          fin <= 1'b1;
        end else begin
          if (scan_b[0]) acc_m <= add_mod(acc_m, dbl_p, mod_q);
          dbl_p  <= add_mod(dbl_p, dbl_p, mod_q);
          scan_b <= scan_b >> 1;
        end
      end
    end
  end

  assign prod = acc_m;

  // partial values stay reduced, so the final value needs no correction
  assert_mm_partials_reduced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (acc_m < mod_q) && (dbl_p < mod_q));
  // each completion is a lone pulse
  assert_mm_fin_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/modexp_lr.sv
module modexp_lr
  import modexp_pkg::*;
#(
  parameter int W  = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] base,
  input  logic [W-1:0] exponent,
  input  logic [W-1:0] modulus,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  mx_state_e    st;
  logic [W-1:0] exp_q, n_q, base_red, run_val;
  logic [IW-1:0] idx, lead_pos, idx_dn;
  logic         mm_go, mm_fin;
  logic [W-1:0] mm_a, mm_b, mm_p, unit;

  modexp_lead_one #(.W(W)) u_lead (.vec(exponent), .pos(lead_pos));

  modexp_mulmod #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mm_go),
    .op_a(mm_a), .op_b(mm_b), .op_n(n_q),
    .fin(mm_fin), .prod(mm_p)
  );

  assign unit   = (modulus == W'(1)) ? '0 : W'(1);
  assign idx_dn = idx - IW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      exp_q    <= '0;
      n_q      <= '0;
      base_red <= '0;
      run_val  <= '0;
      idx      <= '0;
      mm_go    <= 1'b0;
      mm_a     <= '0;
      mm_b     <= '0;
      result   <= '0;
    end else begin
      mm_go <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          exp_q <= exponent;
          n_q   <= modulus;
          if (exponent == '0) begin
            result <= unit;
            st     <= ST_DONE;
          end else begin
            idx     <= lead_pos;
            run_val <= unit;
            mm_a    <= unit;       // unit * base brings base below n
            mm_b    <= base;
            mm_go   <= 1'b1;
            st      <= ST_RED;
          end
        end
        ST_RED: if (mm_fin) begin
          base_red <= mm_p;
          mm_a     <= mm_p;
          mm_b     <= run_val;     // top bit is always one
          mm_go    <= 1'b1;
          st       <= ST_MUL;
        end
        ST_MUL: if (mm_fin) begin
          run_val <= mm_p;
          if (idx == '0) begin
            result <= mm_p;
            st     <= ST_DONE;
          end else begin
            mm_a  <= mm_p;
            mm_b  <= mm_p;
            mm_go <= 1'b1;
            st    <= ST_SQR;
          end
        end
        ST_SQR: if (mm_fin) begin
          run_val <= mm_p;
          idx     <= idx_dn;
          if (exp_q[idx_dn]) begin
            mm_a  <= base_red;
            mm_b  <= mm_p;
            mm_go <= 1'b1;
            st    <= ST_MUL;
          end else if (idx_dn == '0) begin
            result <= mm_p;
            st     <= ST_DONE;
          end else begin
            mm_a  <= mm_p;
            mm_b  <= mm_p;
            mm_go <= 1'b1;
            st    <= ST_SQR;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);
  assign done = (st == ST_DONE);

  assert_result_below_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < n_q));
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_zero_exp_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && exponent == '0) |=> (done && !mm_go));
  assert_operands_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(exp_q) && $stable(n_q)));
  assert_mod_one_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && n_q == W'(1)) |-> (result == '0));
endmodule

// File: tb/modexp_lr_tb.sv
module modexp_lr_tb_top;
  localparam int CLK_NS = 10;
  localparam int OP_LIMIT = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] base = '0, exponent = '0, modulus = 16'd1;
  logic        busy, done;
  logic [15:0] result;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  modexp_lr dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base),
    .exponent(exponent), .modulus(modulus),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [15:0] ref_pow(input logic [15:0] a,
                                          input logic [15:0] e,
                                          input logic [15:0] n);
    longint unsigned r, b;
    r = 64'd1 % longint'(n);
    b = longint'(a) % longint'(n);
    for (int i = 15; i >= 0; i--) begin
      r = (r * r) % longint'(n);
      if (e[i]) r = (r * b) % longint'(n);
    end
    return r[15:0];
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // runs one request; optionally injects a second start while busy
  task automatic run_op(input logic [15:0] a, input logic [15:0] e,
                        input logic [15:0] n, input bit inject,
                        output logic [15:0] got, output int cyc);
    int extra_done;
    @(negedge clk);
    base = a; exponent = e; modulus = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    extra_done = 0;
    if (inject && !done) begin
      base = 16'd3; exponent = 16'd7; modulus = 16'd100; start = 1'b1;
    end
    while (!done && cyc < OP_LIMIT) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    got = result;
    if (!done) begin
      n_bad++;
      $display("FAIL R3: no done after %0d cycles, got %0d expected done", cyc, 0);
    end
    // done must drop and not come back for an ignored request
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) extra_done++;
    end
    check("R3 single done", extra_done, 0);
  endtask

  initial begin
    #(CLK_NS * 195000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, c, a, e, n;
    int cyc, cyc_short, cyc_long;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R8 busy", busy, 0);
    check("R8 done", done, 0);
    check("R8 result", result, 0);
    rst_n = 1'b1;

    run_op(16'd8, 16'd5, 16'd91, 1'b0, got, cyc);
    check("R1 8^5 mod 91", got, 8);
    run_op(16'd8, 16'd29, 16'd91, 1'b0, got, cyc);
    check("R1 8^29 mod 91", got, 8);

    run_op(16'd1234, 16'd0, 16'd91, 1'b0, got, cyc);
    check("R2 zero exp result", got, 1);
    check("R2 zero exp latency", cyc, 1);

    run_op(16'd777, 16'd0, 16'd1, 1'b0, got, cyc);
    check("R6 zero exp mod 1", got, 0);
    run_op(16'd777, 16'd12345, 16'd1, 1'b0, got, cyc);
    check("R6 mod 1", got, 0);

    run_op(16'd65535, 16'd3, 16'd7, 1'b0, got, cyc);
    check("R1 base above modulus", got, ref_pow(16'd65535, 16'd3, 16'd7));
    run_op(16'd54321, 16'hFFFF, 16'hFFFF, 1'b0, got, cyc_long);
    check("R1 full exponent", got, ref_pow(16'd54321, 16'hFFFF, 16'hFFFF));
    check("R5 below modulus", got < 16'hFFFF, 1);
    run_op(16'd54321, 16'd1, 16'hFFFF, 1'b0, got, cyc_short);
    check("R1 exponent one", got, 16'd54321);
    check("R1 short exponent is faster", cyc_short < cyc_long, 1);

    run_op(16'd8, 16'd29, 16'd91, 1'b1, got, cyc);
    check("R4 start while busy ignored", got, 8);

    // n = 101*43, phi = 4200, e = 11, d = 2291
    run_op(16'd88, 16'd11, 16'd4343, 1'b0, c, cyc);
    check("R7 cipher", c, ref_pow(16'd88, 16'd11, 16'd4343));
    run_op(c, 16'd2291, 16'd4343, 1'b0, got, cyc);
    check("R7 round trip", got, 88);

    for (int v = 0; v < 120; v++) begin
      a = 16'($urandom);
      e = (v % 4 == 0) ? 16'($urandom_range(0, 31)) : 16'($urandom);
      n = 16'($urandom_range(1, 65535));
      run_op(a, e, n, 1'b0, got, cyc);
      check("R1 random", got, ref_pow(a, e, n));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule